// File: doc/BRIEF.md
# Touch Poll Engine Control Register

This block holds the 32-bit control word of a capacitive touch polling engine. Software writes the word over a simple bus write port and reads it back on a read port. The block keeps the operating mode within its legal transitions. It also passes the mode and DMA settings on to a slower sequencer, which is clocked from a divided functional clock.

The slow side is represented by a tick input. This is a level signal, synchronous to `clk`, that follows the divided clock. Any write that changes the mode or DMA setting sets a busy flag. After the second rising edge of the tick, the change is treated as delivered: the mirrored slow-side values update and busy clears.

A one-shot poll request does not stay in the register. When it is delivered it produces a single-cycle start pulse and the mode returns to idle. The mode returning to idle says nothing about whether the poll has finished.

Top module: `tctl_ctrl_reg`

## Requirements
- R1: After reset, every bit of the read word is 0, and busy, sync_mode, sync_dma and poll_go are all 0.
- R2: The word layout is as follows, and every field reads back exactly what was accepted:
  - mode: bits 1:0
  - arrangement: bits 3:2
  - trigger: bit 4
  - wait: bit 5
  - DMA: bits 7:6
  - divider: bits 11:8
  - idle-pin policy: bits 13:12
  - busy: bit 15
  - X select mask: bits 31:16
- R3: Mode codes are 0 idle, 1 one-shot poll, 2 periodic, 3 low-power wake. From mode 0, any written code is taken. From a non-zero mode, writing the same code keeps it, and writing a different non-zero code leaves the mode at 0.
- R4: Writing mode 0 always returns the mode to idle. Once propagated, sync_mode is 0, which stops the sequencer's counters.
- R5: An accepted mode 1 reads as 1 until it is propagated. In the cycle after propagation, poll_go is high for exactly one cycle, the mode reads 0 and sync_mode stays 0.
- R6: A write that changes the mode or the DMA field sets busy in the next cycle. A write that changes neither leaves busy as it was.
- R7: Busy clears on the second rising edge of fclk_tick after the last changing write, counting only edges after that write's cycle. In that same update, sync_mode and sync_dma take the register values. At no other time do they change.
- R8: Write bits 15:14 are ignored. Read bit 15 shows busy and read bit 14 reads 0.
- R9: The DMA field can be changed while the mode is non-zero, and doing so leaves the mode unchanged.
- R10: The decoded field outputs always equal the corresponding fields of the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write word |
| fclk_tick | input | 1 | Divided functional clock level, synchronous to clk |
| rd_data | output | 32 | Read word |
| poll_mode | output | 2 | Current mode |
| arr_type | output | 2 | Sensor arrangement select |
| trig_sel | output | 1 | Trigger source select |
| wait_rd | output | 1 | Wait-for-readout enable |
| dma_mode | output | 2 | DMA request mode |
| clk_div | output | 4 | Functional clock divider |
| idle_pin | output | 2 | Policy for inactive X pins |
| x_sel | output | 16 | X pin select mask |
| busy | output | 1 | Change still propagating |
| sync_mode | output | 2 | Mode as seen by the slow sequencer |
| sync_dma | output | 2 | DMA mode as seen by the slow sequencer |
| poll_go | output | 1 | One-cycle start of a one-shot poll |

## Verification
The hardest situation to reach is a second changing write that lands while busy is still counting, especially when one tick edge has already been seen or an edge arrives in the write's own cycle. In that case the count must restart and the earlier value must never reach the slow side. Random writes at about one cycle in four are mixed with a randomly toggling tick, which makes such overlaps frequent. Directed sequences add the illegal non-zero-to-non-zero change, the same-code rewrite, and the one-shot self-clear.

// File: rtl/tctl_ctrl_reg.sv
module tctl_ctrl_reg #(
  parameter int EDGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        fclk_tick,
  output logic [31:0] rd_data,
  output logic [1:0]  poll_mode,
  output logic [1:0]  arr_type,
  output logic        trig_sel,
  output logic        wait_rd,
  output logic [1:0]  dma_mode,
  output logic [3:0]  clk_div,
  output logic [1:0]  idle_pin,
  output logic [15:0] x_sel,
  output logic        busy,
  output logic [1:0]  sync_mode,
  output logic [1:0]  sync_dma,
  output logic        poll_go
);
  localparam int CW = $clog2(EDGES + 1);

  logic [CW-1:0] cnt;
  logic          tick_q;
  logic [1:0]    mode_nxt;
  logic          chg, rise, last;

  always_comb begin
    if (poll_mode == 2'd0 || wr_data[1:0] == poll_mode) mode_nxt = wr_data[1:0];
    else                                                mode_nxt = 2'd0;
  end

  assign chg  = (mode_nxt != poll_mode) || (wr_data[7:6] != dma_mode);
  assign rise = fclk_tick & ~tick_q;
  assign last = (cnt == CW'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_mode <= '0; arr_type <= '0; trig_sel <= 1'b0; wait_rd <= 1'b0;
      dma_mode  <= '0; clk_div  <= '0; idle_pin <= '0;   x_sel   <= '0;
      busy <= 1'b0; cnt <= '0; tick_q <= 1'b0;
      sync_mode <= '0; sync_dma <= '0; poll_go <= 1'b0;
    end else begin
      tick_q  <= fclk_tick;
      poll_go <= 1'b0;
      if (wr_en) begin
        poll_mode <= mode_nxt;
        arr_type  <= wr_data[3:2];
        trig_sel  <= wr_data[4];
        wait_rd   <= wr_data[5];
        dma_mode  <= wr_data[7:6];
        clk_div   <= wr_data[11:8];
        idle_pin  <= wr_data[13:12];
        x_sel     <= wr_data[31:16];
      end
      if (wr_en && chg) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy && rise) begin
        if (last) begin
          busy     <= 1'b0;
          cnt      <= '0;
          sync_dma <= dma_mode;
          if (poll_mode == 2'd1) begin
            poll_go   <= 1'b1;
            sync_mode <= 2'd0;
            poll_mode <= 2'd0;
          end else begin
            sync_mode <= poll_mode;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign rd_data = {x_sel, busy, 1'b0, idle_pin, clk_div, dma_mode,
                    wait_rd, trig_sel, arr_type, poll_mode};
endmodule

// File: rtl/tctl_ctrl_reg_chk.sv
module tctl_ctrl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [1:0]  poll_mode,
  input logic [1:0]  dma_mode,
  input logic        busy,
  input logic [1:0]  sync_mode,
  input logic [1:0]  sync_dma,
  input logic        poll_go
);
  p_illegal_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && poll_mode != 2'd0 && wr_data[1:0] != 2'd0 && wr_data[1:0] != poll_mode)
    |=> (poll_mode == 2'd0 || poll_go));

  p_zero_write_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1:0] == 2'd0) |=> (poll_mode == 2'd0));

  p_go_leaves_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_go |-> (poll_mode == 2'd0 && sync_mode == 2'd0 && !busy));

  p_busy_on_dma_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:6] != dma_mode) |=> busy);

  p_sync_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> ($stable(sync_mode) && $stable(sync_dma)));
endmodule

bind tctl_ctrl_reg tctl_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .poll_mode(poll_mode), .dma_mode(dma_mode), .busy(busy),
  .sync_mode(sync_mode), .sync_dma(sync_dma), .poll_go(poll_go)
);

// File: tb/tctl_ctrl_reg_tb.sv
`timescale 1ns/1ps
module tctl_ctrl_reg_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, fclk_tick = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  poll_mode, arr_type, dma_mode, idle_pin, sync_mode, sync_dma;
  logic        trig_sel, wait_rd, busy, poll_go;
  logic [3:0]  clk_div;
  logic [15:0] x_sel;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  logic [1:0]  m_mode, m_dma, m_smode, m_sdma;
  logic [31:0] m_word;
  bit          m_busy, m_go, m_tq;
  int          m_cnt;

  always #2.5 clk = ~clk;

  tctl_ctrl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fclk_tick(fclk_tick), .rd_data(rd_data), .poll_mode(poll_mode),
    .arr_type(arr_type), .trig_sel(trig_sel), .wait_rd(wait_rd),
    .dma_mode(dma_mode), .clk_div(clk_div), .idle_pin(idle_pin),
    .x_sel(x_sel), .busy(busy), .sync_mode(sync_mode),
    .sync_dma(sync_dma), .poll_go(poll_go)
  );

  function automatic logic [1:0] legal(input logic [1:0] cur, input logic [1:0] req);
    return (cur == 2'd0 || req == cur) ? req : 2'd0;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = m_word;
    w[1:0] = m_mode; w[7:6] = m_dma; w[15] = m_busy; w[14] = 1'b0;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input bit wr, input logic [31:0] d, input bit tk);
    bit rise = tk && !m_tq;
    logic [1:0] nm;
    m_go = 0;
    if (wr) begin
      nm = legal(m_mode, d[1:0]);
      m_word = d;
      if (nm != m_mode || d[7:6] != m_dma) begin
        m_busy = 1; m_cnt = 0;
        m_mode = nm; m_dma = d[7:6];
        rise = 0;
      end
    end
    if (m_busy && rise) begin
      if (m_cnt == 1) begin
        m_busy = 0; m_cnt = 0; m_sdma = m_dma;
        if (m_mode == 2'd1) begin m_go = 1; m_smode = 2'd0; m_mode = 2'd0; end
        else m_smode = m_mode;
      end else m_cnt++;
    end
    m_tq = tk;
  endtask

  task automatic compare(input string t);
    chk({t, " R2 read word"}, rd_data, exp_word());
    chk("R3 mode", {30'd0, poll_mode}, {30'd0, m_mode});
    chk("R7 busy", {31'd0, busy}, {31'd0, m_busy});
    chk("R7 sync_mode", {30'd0, sync_mode}, {30'd0, m_smode});
    chk("R7 sync_dma", {30'd0, sync_dma}, {30'd0, m_sdma});
    chk("R5 poll_go", {31'd0, poll_go}, {31'd0, m_go});
    chk("R10 fields", {x_sel, 2'b00, idle_pin, clk_div, dma_mode, wait_rd, trig_sel, arr_type, poll_mode},
        {rd_data[31:16], 2'b00, rd_data[13:0]});
  endtask

  task automatic step(input string t, input bit wr, input logic [31:0] d, input bit tk);
    @(negedge clk);
    wr_en = wr; wr_data = d; fclk_tick = tk;
    model(wr, d, tk);
    @(posedge clk); #1;
    compare(t);
  endtask

  task automatic settle();
    step("R7 tick", 0, '0, 1); step("R7 tick", 0, '0, 0);
    step("R7 tick", 0, '0, 1); step("R7 tick", 0, '0, 0);
  endtask

  initial begin
    #750000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_mode = 0; m_dma = 0; m_smode = 0; m_sdma = 0; m_word = 0;
    m_busy = 0; m_go = 0; m_tq = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    chk("R1 reset word", rd_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    step("R3 enter periodic", 1, 32'hA5A5_0B32, 0);
    chk("R6 busy after mode write", {31'd0, busy}, 32'd1);
    chk("R8 bits 15:14 ignored", {30'd0, rd_data[15:14]}, 32'd2);
    settle();
    chk("R7 sync periodic", {30'd0, sync_mode}, 32'd2);
    step("R3 non-zero change", 1, 32'h0000_0003, 0);
    chk("R3 falls to idle", {30'd0, poll_mode}, 32'd0);
    settle();
    step("R3 enter low power", 1, 32'h0000_0003, 0);
    settle();
    step("R3 same code rewrite", 1, 32'h1234_0003, 0);
    chk("R6 no busy on same", {31'd0, busy}, 32'd0);
    step("R9 dma change active", 1, 32'h0000_00C3, 0);
    chk("R9 mode kept", {30'd0, poll_mode}, 32'd3);
    settle();
    step("R4 write idle", 1, 32'h0000_00C0, 0);
    settle();
    chk("R4 sync idle", {30'd0, sync_mode}, 32'd0);
    step("R5 one-shot", 1, 32'h0000_0001, 0);
    step("R5 tick", 0, '0, 1); step("R5 tick", 0, '0, 0);
    step("R5 tick", 0, '0, 1);
    chk("R5 go pulse", {31'd0, poll_go}, 32'd1);
    step("R5 after", 0, '0, 0);
    chk("R5 go single", {31'd0, poll_go}, 32'd0);
    step("R7 edge same cycle", 1, 32'h0000_0002, 1);
    step("R7 restart", 0, '0, 0);
    step("R7 restart", 1, 32'h0000_0042, 1);
    step("R7 restart", 0, '0, 0);
    settle();

    for (int i = 0; i < 20000; i++) begin
      logic [31:0] d = $urandom;
      bit wr = ($urandom % 4) == 0;
      bit tk = $urandom % 2;
      step("rand", wr, d, tk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule